// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks data-cache misses that are still outstanding, so that the cache can keep serving other accesses while a line is being fetched. It sits between a first-level data cache and the next level of memory. Every miss presented to it is looked up by block address among the entries whose fill has not yet come back. A miss to a new block takes a free entry and records the access as that entry's first target. A miss to a block already being fetched is merged into the existing entry as one more target and costs no extra downstream traffic.

Each occupied entry raises a downstream request carrying its block address and its own index. The request stays up until the next level accepts it. When the next level answers with that index, the block replays every recorded access as a completion, one per cycle, in the order the accesses were recorded, and then frees the entry. Refused accesses are reported at once by kind: a refused load goes back to the issue-ready queue and a refused store has its commit held. A fetch-stall output stays high from the refusal until an entry is released.

Top module: `mshr_file`

## Requirements
- R1: A miss whose block address (word address with the low 3 word-offset bits dropped) matches no open entry is accepted in the same cycle and takes the free entry with the lowest index, recording the access as its only target.
- R2: A miss whose block matches an open entry with a free target slot is accepted, appends one target to that entry and raises no new downstream request.
- R3: From the cycle after an allocation, `req_valid` is high with `req_block` equal to the block address and `req_entry` equal to the allocated index; it stays high until a cycle with `req_ready` high, and drops in the cycle after.
- R4: In the cycle after a response for an entry, completions start on `done_valid`, one per cycle, in the order the targets were recorded, each carrying the access tag, the store flag (1 = store) and the word offset within the line; after the last one the entry is free. Responses for several entries are drained one entry after another with no idle cycle between them.
- R5: A miss is refused when it needs a new entry and none is free, or when its matching entry already holds 4 targets; a refused load raises `load_replay` in the same cycle and leaves `miss_accept` low.
- R6: A refused store raises `store_hold` in the same cycle and leaves `miss_accept` low.
- R7: `fetch_stall` rises in the cycle after any refusal and stays high until the cycle after an entry is released.
- R8: A miss whose block matches an entry whose response arrives in the same cycle is not merged; it is handled as a new block and allocates another entry with its own request, and the completing entry replays only its own targets.
- R9: After reset no entry is open and `miss_accept`, `load_replay`, `store_hold`, `fetch_stall`, `req_valid` and `done_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_waddr | input | 30 | Word address of the missing access |
| miss_tag | input | 6 | Access tag of the missing access |
| miss_is_store | input | 1 | 1 for a store, 0 for a load |
| miss_accept | output | 1 | The miss was allocated or merged |
| load_replay | output | 1 | The miss was a load and was refused |
| store_hold | output | 1 | The miss was a store and was refused |
| fetch_stall | output | 1 | A refusal is pending |
| req_valid | output | 1 | A downstream line request is offered |
| req_ready | input | 1 | The next level takes the request |
| req_block | output | 27 | Block address of the request |
| req_entry | output | 2 | Entry index carried with the request |
| rsp_valid | input | 1 | A line fill has returned |
| rsp_entry | input | 2 | Entry index of the returned fill |
| done_valid | output | 1 | A completion is presented |
| done_tag | output | 6 | Access tag of the completion |
| done_is_store | output | 1 | Store flag of the completion |
| done_word | output | 3 | Word offset of the completion |

## Verification
The assertions assume that the next level answers only for an entry whose request it has already taken, answers each entry once, and sends at most one response per cycle; under those conditions at most one open entry can match a block and a pending request can only leave when accepted. The stimulus keeps to this by sending each response only after the request for that index has been seen and consumed, and by waiting for each entry's replay before reusing its index. Misses are held for exactly one cycle, so the same-cycle outcome checks see a single access at a time.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

   typedef enum logic [1:0] {
      MISS_IDLE,
      MISS_ALLOC,
      MISS_MERGE,
      MISS_REFUSE
   } miss_kind_e;

   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mshr_pick_low.sv
module mshr_pick_low #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (N == 1) begin : g_single
         assign any = req[0];
         assign idx = '0;
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
         assign any = |req;
      end
   endgenerate

endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
   parameter int BLK_W  = 27,
   parameter int TGT_N  = 4,
   parameter int SLOT_W = 10,
   parameter int PTR_W  = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              append_i,
   input  logic [BLK_W-1:0]  blk_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              fill_i,
   input  logic              sent_i,
   input  logic              release_i,
   input  logic [PTR_W-1:0]  rd_ptr_i,
   output logic              valid_o,
   output logic              filled_o,
   output logic              pend_o,
   output logic [BLK_W-1:0]  blk_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [SLOT_W-1:0] rd_slot_o
);

   logic              valid_q;
   logic              filled_q;
   logic              pend_q;
   logic [BLK_W-1:0]  blk_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_W-1:0] slots_q [TGT_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         filled_q <= 1'b0;
         pend_q   <= 1'b0;
         blk_q    <= '0;
         cnt_q    <= '0;
      end else if (alloc_i) begin
         valid_q  <= 1'b1;
         filled_q <= 1'b0;
         pend_q   <= 1'b1;
         blk_q    <= blk_i;
         cnt_q    <= CNT_W'(1);
      end else begin
         if (append_i) cnt_q <= cnt_q + CNT_W'(1);
         if (fill_i) filled_q <= 1'b1;
         if (sent_i) pend_q <= 1'b0;
         if (release_i) begin
            valid_q  <= 1'b0;
            filled_q <= 1'b0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_i) slots_q[0] <= slot_i;
      else if (append_i) slots_q[cnt_q[PTR_W-1:0]] <= slot_i;
   end

   assign valid_o   = valid_q;
   assign filled_o  = filled_q;
   assign pend_o    = pend_q;
   assign blk_o     = blk_q;
   assign cnt_o     = cnt_q;
   assign rd_slot_o = slots_q[rd_ptr_i];

endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_OFS_W  = 5,
   parameter int BYTE_OFS_W  = 2,
   parameter int NUM_ENTRIES = 4,
   parameter int NUM_TARGETS = 4,
   parameter int TAG_W       = 6,
   localparam int BLK_W  = ADDR_W - LINE_OFS_W,
   localparam int WORD_W = LINE_OFS_W - BYTE_OFS_W,
   localparam int WA_W   = ADDR_W - BYTE_OFS_W,
   localparam int IDX_W  = idx_bits(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [WA_W-1:0]   miss_waddr,
   input  logic [TAG_W-1:0]  miss_tag,
   input  logic              miss_is_store,
   output logic              miss_accept,
   output logic              load_replay,
   output logic              store_hold,
   output logic              fetch_stall,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [BLK_W-1:0]  req_block,
   output logic [IDX_W-1:0]  req_entry,
   input  logic              rsp_valid,
   input  logic [IDX_W-1:0]  rsp_entry,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic              done_is_store,
   output logic [WORD_W-1:0] done_word
);

   localparam int PTR_W  = idx_bits(NUM_TARGETS);
   localparam int CNT_W  = $clog2(NUM_TARGETS + 1);
   localparam int SLOT_W = TAG_W + 1 + WORD_W;

   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("mshr_file: NUM_ENTRIES must be at least 2");
   end
   if (NUM_TARGETS < 2) begin : g_bad_targets
      $error("mshr_file: NUM_TARGETS must be at least 2");
   end
   if (WORD_W < 1 || BLK_W < 1) begin : g_bad_widths
      $error("mshr_file: line offset must exceed byte offset and fit the address");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("mshr_file: TAG_W must be positive");
   end

   // lookup side
   logic [BLK_W-1:0]  miss_blk;
   logic [WORD_W-1:0] miss_word;
   logic [SLOT_W-1:0] miss_slot;

   assign miss_blk  = miss_waddr[WA_W-1:WORD_W];
   assign miss_word = miss_waddr[WORD_W-1:0];
   assign miss_slot = {miss_tag, miss_is_store, miss_word};

   // per-entry state views
   logic [NUM_ENTRIES-1:0] ent_valid;
   logic [NUM_ENTRIES-1:0] ent_filled;
   logic [NUM_ENTRIES-1:0] ent_pend;
   logic [BLK_W-1:0]       ent_blk  [NUM_ENTRIES];
   logic [CNT_W-1:0]       ent_cnt  [NUM_ENTRIES];
   logic [SLOT_W-1:0]      ent_slot [NUM_ENTRIES];

   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [NUM_ENTRIES-1:0] free_vec;
   logic [NUM_ENTRIES-1:0] drain_req;
   logic [NUM_ENTRIES-1:0] alloc_vec;
   logic [NUM_ENTRIES-1:0] append_vec;
   logic [NUM_ENTRIES-1:0] fill_vec;
   logic [NUM_ENTRIES-1:0] sent_vec;
   logic [NUM_ENTRIES-1:0] release_vec;

   logic             any_hit;
   logic [IDX_W-1:0] hit_idx;
   logic             any_free;
   logic [IDX_W-1:0] free_idx;
   logic             any_drain;
   logic [IDX_W-1:0] drain_pick;

   // drain engine state
   logic             drain_busy;
   logic [IDX_W-1:0] drain_idx;
   logic [PTR_W-1:0] drain_ptr;
   logic [IDX_W-1:0] cur_idx;
   logic [PTR_W-1:0] rd_ptr;
   logic             drain_last;

   miss_kind_e miss_kind;
   logic       hit_full;
   logic       refuse;
   logic       alloc_any;
   logic       stall_q;

   genvar g;
   generate
      for (g = 0; g < NUM_ENTRIES; g++) begin : g_ent
         // an entry whose fill is landing this cycle is closed to merges
         assign hit_vec[g]     = ent_valid[g] && !ent_filled[g]
                                 && !(rsp_valid && rsp_entry == IDX_W'(g))
                                 && ent_blk[g] == miss_blk;
         assign free_vec[g]    = !ent_valid[g];
         assign drain_req[g]   = ent_valid[g] && ent_filled[g];
         assign alloc_vec[g]   = miss_kind == MISS_ALLOC && free_idx == IDX_W'(g);
         assign append_vec[g]  = miss_kind == MISS_MERGE && hit_idx == IDX_W'(g);
         assign fill_vec[g]    = rsp_valid && rsp_entry == IDX_W'(g);
         assign sent_vec[g]    = req_valid && req_ready && req_entry == IDX_W'(g);
         assign release_vec[g] = done_valid && drain_last && cur_idx == IDX_W'(g);

         mshr_entry #(
            .BLK_W  (BLK_W),
            .TGT_N  (NUM_TARGETS),
            .SLOT_W (SLOT_W),
            .PTR_W  (PTR_W),
            .CNT_W  (CNT_W)
         ) i_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[g]),
            .append_i  (append_vec[g]),
            .blk_i     (miss_blk),
            .slot_i    (miss_slot),
            .fill_i    (fill_vec[g]),
            .sent_i    (sent_vec[g]),
            .release_i (release_vec[g]),
            .rd_ptr_i  (rd_ptr),
            .valid_o   (ent_valid[g]),
            .filled_o  (ent_filled[g]),
            .pend_o    (ent_pend[g]),
            .blk_o     (ent_blk[g]),
            .cnt_o     (ent_cnt[g]),
            .rd_slot_o (ent_slot[g])
         );
      end
   endgenerate

   mshr_pick_low #(.N(NUM_ENTRIES), .IW(IDX_W)) i_pick_hit (
      .req (hit_vec),
      .any (any_hit),
      .idx (hit_idx)
   );

   mshr_pick_low #(.N(NUM_ENTRIES), .IW(IDX_W)) i_pick_free (
      .req (free_vec),
      .any (any_free),
      .idx (free_idx)
   );

   mshr_pick_low #(.N(NUM_ENTRIES), .IW(IDX_W)) i_pick_req (
      .req (ent_pend),
      .any (req_valid),
      .idx (req_entry)
   );

   mshr_pick_low #(.N(NUM_ENTRIES), .IW(IDX_W)) i_pick_drain (
      .req (drain_req),
      .any (any_drain),
      .idx (drain_pick)
   );

   // miss outcome, decided in the cycle of the lookup
   assign hit_full = ent_cnt[hit_idx] == CNT_W'(NUM_TARGETS);

   always_comb begin
      if (!miss_valid)    miss_kind = MISS_IDLE;
      else if (any_hit)   miss_kind = hit_full ? MISS_REFUSE : MISS_MERGE;
      else if (any_free)  miss_kind = MISS_ALLOC;
      else                miss_kind = MISS_REFUSE;
   end

   assign refuse      = miss_kind == MISS_REFUSE;
   assign alloc_any   = miss_kind == MISS_ALLOC;
   assign miss_accept = miss_kind == MISS_ALLOC || miss_kind == MISS_MERGE;
   assign load_replay = refuse && !miss_is_store;
   assign store_hold  = refuse && miss_is_store;

   // downstream request
   assign req_block = ent_blk[req_entry];

   // completion replay
   assign cur_idx    = drain_busy ? drain_idx : drain_pick;
   assign rd_ptr     = drain_busy ? drain_ptr : '0;
   assign done_valid = drain_busy || any_drain;
   assign drain_last = ent_cnt[cur_idx] == CNT_W'(rd_ptr) + CNT_W'(1);

   assign {done_tag, done_is_store, done_word} = ent_slot[cur_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drain_busy <= 1'b0;
         drain_idx  <= '0;
         drain_ptr  <= '0;
      end else if (done_valid) begin
         if (drain_last) begin
            drain_busy <= 1'b0;
            drain_ptr  <= '0;
         end else begin
            drain_busy <= 1'b1;
            drain_idx  <= cur_idx;
            drain_ptr  <= rd_ptr + PTR_W'(1);
         end
      end
   end

   // refusal pending until an entry is given back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              stall_q <= 1'b0;
      else if (refuse)         stall_q <= 1'b1;
      else if (|release_vec)   stall_q <= 1'b0;
   end

   assign fetch_stall = stall_q;

endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
   parameter int NUM_ENTRIES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   miss_valid,
   input logic                   miss_is_store,
   input logic                   miss_accept,
   input logic                   load_replay,
   input logic                   store_hold,
   input logic                   fetch_stall,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic                   alloc_any,
   input logic [NUM_ENTRIES-1:0] hit_vec
);

   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> $onehot({miss_accept, load_replay, store_hold})); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_valid |-> !(miss_accept || load_replay || store_hold)); // R9

   AST_REPLAY_IS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_replay |-> !miss_is_store); // R5

   AST_HOLD_IS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      store_hold |-> miss_is_store); // R6

   AST_ALLOC_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_any |=> req_valid); // R3

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> req_valid); // R3

   AST_STALL_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_replay || store_hold) |=> fetch_stall); // R7

endmodule

bind mshr_file mshr_file_chk #(.NUM_ENTRIES(NUM_ENTRIES)) i_mshr_file_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .miss_valid    (miss_valid),
   .miss_is_store (miss_is_store),
   .miss_accept   (miss_accept),
   .load_replay   (load_replay),
   .store_hold    (store_hold),
   .fetch_stall   (fetch_stall),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .alloc_any     (alloc_any),
   .hit_vec       (hit_vec)
);

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [29:0] miss_waddr = '0;
   logic [5:0]  miss_tag = '0;
   logic        miss_is_store = 1'b0;
   logic        miss_accept, load_replay, store_hold, fetch_stall;
   logic        req_valid;
   logic        req_ready = 1'b1;
   logic [26:0] req_block;
   logic [1:0]  req_entry;
   logic        rsp_valid = 1'b0;
   logic [1:0]  rsp_entry = '0;
   logic        done_valid;
   logic [5:0]  done_tag;
   logic        done_is_store;
   logic [2:0]  done_word;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic r_acc, r_rep, r_hold;

   always #2 clk = ~clk;

   mshr_file i_mshr_file (
      .clk (clk), .rst_n (rst_n),
      .miss_valid (miss_valid), .miss_waddr (miss_waddr),
      .miss_tag (miss_tag), .miss_is_store (miss_is_store),
      .miss_accept (miss_accept), .load_replay (load_replay),
      .store_hold (store_hold), .fetch_stall (fetch_stall),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_block (req_block), .req_entry (req_entry),
      .rsp_valid (rsp_valid), .rsp_entry (rsp_entry),
      .done_valid (done_valid), .done_tag (done_tag),
      .done_is_store (done_is_store), .done_word (done_word)
   );

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic chk_eq(input string what, input longint act, input longint exp);
      chk(act == exp, what, act, exp);
   endtask

   // present one miss for one cycle; called and returns at a falling edge
   task automatic do_miss(input logic [31:0] addr, input logic [5:0] tag, input logic st);
      miss_valid    = 1'b1;
      miss_waddr    = addr[31:2];
      miss_tag      = tag;
      miss_is_store = st;
      #1;
      r_acc  = miss_accept;
      r_rep  = load_replay;
      r_hold = store_hold;
      @(negedge clk);
      miss_valid = 1'b0;
   endtask

   task automatic do_rsp(input logic [1:0] e);
      rsp_valid = 1'b1;
      rsp_entry = e;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic chk_done(input string what, input logic [5:0] tag, input logic st, input logic [2:0] w);
      chk_eq({what, " done_valid"}, done_valid, 1);
      chk_eq({what, " tag"}, done_tag, tag);
      chk_eq({what, " store"}, done_is_store, st);
      chk_eq({what, " word"}, done_word, w);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_eq("R9 req_valid", req_valid, 0);
      chk_eq("R9 done_valid", done_valid, 0);
      chk_eq("R9 fetch_stall", fetch_stall, 0);
      chk_eq("R9 outcome", {miss_accept, load_replay, store_hold}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_primary();
      req_ready = 1'b0;
      do_miss(32'h1004, 6'd1, 1'b0);
      chk_eq("R1 primary accept", r_acc, 1);
      chk_eq("R3 req_valid", req_valid, 1);
      chk_eq("R3 req_block", req_block, 27'h80);
      chk_eq("R3 req_entry", req_entry, 0);
      @(negedge clk);
      chk_eq("R3 req held while not ready", req_valid, 1);
      req_ready = 1'b1;
      @(negedge clk);
      chk_eq("R3 req drops after ready", req_valid, 0);
   endtask

   task automatic t_merge_and_refuse();
      do_miss(32'h1008, 6'd2, 1'b1);
      chk_eq("R2 merge accept", r_acc, 1);
      chk_eq("R2 no new request", req_valid, 0);
      do_miss(32'h100C, 6'd3, 1'b0);
      do_miss(32'h101C, 6'd4, 1'b1);
      chk_eq("R2 fourth target accept", r_acc, 1);
      chk_eq("R2 still no request", req_valid, 0);
      do_miss(32'h1010, 6'd5, 1'b0);
      chk_eq("R5 full entry load refused accept", r_acc, 0);
      chk_eq("R5 load_replay", r_rep, 1);
      chk_eq("R5 no store_hold", r_hold, 0);
      chk_eq("R7 stall after refusal", fetch_stall, 1);
      do_miss(32'h1014, 6'd6, 1'b1);
      chk_eq("R6 store refused accept", r_acc, 0);
      chk_eq("R6 store_hold", r_hold, 1);
      chk_eq("R6 no load_replay", r_rep, 0);
   endtask

   task automatic t_fill();
      do_rsp(2'd0);
      chk_done("R4 first", 6'd1, 1'b0, 3'd1);
      chk_eq("R7 stall held during replay", fetch_stall, 1);
      @(negedge clk);
      chk_done("R4 second", 6'd2, 1'b1, 3'd2);
      @(negedge clk);
      chk_done("R4 third", 6'd3, 1'b0, 3'd3);
      @(negedge clk);
      chk_done("R4 fourth", 6'd4, 1'b1, 3'd7);
      @(negedge clk);
      chk_eq("R4 replay ends", done_valid, 0);
      chk_eq("R7 stall clears on release", fetch_stall, 0);
      do_miss(32'h1000, 6'd7, 1'b0);
      chk_eq("R1 freed entry reused accept", r_acc, 1);
      chk_eq("R1 reuse entry 0", req_entry, 0);
   endtask

   task automatic t_exhaust();
      do_miss(32'h2000, 6'd8, 1'b0);
      chk_eq("R1 next entry 1", req_entry, 1);
      do_miss(32'h3000, 6'd9, 1'b0);
      chk_eq("R1 next entry 2", req_entry, 2);
      do_miss(32'h4000, 6'd10, 1'b1);
      chk_eq("R1 next entry 3", req_entry, 3);
      chk_eq("R3 block of entry 3", req_block, 27'h200);
      do_miss(32'h5000, 6'd11, 1'b0);
      chk_eq("R5 no free entry accept", r_acc, 0);
      chk_eq("R5 no free entry replay", r_rep, 1);
      chk_eq("R5 no request for refused", req_valid, 0);
      chk_eq("R7 stall set", fetch_stall, 1);
      do_rsp(2'd2);
      chk_done("R4 single target", 6'd9, 1'b0, 3'd0);
      @(negedge clk);
      chk_eq("R4 single target ends", done_valid, 0);
      chk_eq("R7 stall cleared", fetch_stall, 0);
      do_miss(32'h6000, 6'd12, 1'b0);
      chk_eq("R1 lowest free is 2", req_entry, 2);
      // back-to-back responses drain without gaps
      rsp_valid = 1'b1; rsp_entry = 2'd0;
      @(negedge clk);
      chk_done("R4 chain e0", 6'd7, 1'b0, 3'd0);
      rsp_entry = 2'd1;
      @(negedge clk);
      chk_done("R4 chain e1", 6'd8, 1'b0, 3'd0);
      rsp_entry = 2'd2;
      @(negedge clk);
      chk_done("R4 chain e2", 6'd12, 1'b0, 3'd0);
      rsp_entry = 2'd3;
      @(negedge clk);
      chk_done("R4 chain e3", 6'd10, 1'b1, 3'd0);
      rsp_valid = 1'b0;
      @(negedge clk);
      chk_eq("R4 chain ends", done_valid, 0);
   endtask

   task automatic t_same_cycle();
      do_miss(32'h7000, 6'd20, 1'b0);
      chk_eq("R8 setup entry 0", req_entry, 0);
      @(negedge clk);
      miss_valid = 1'b1; miss_waddr = 30'h1C01; miss_tag = 6'd21; miss_is_store = 1'b1;
      rsp_valid = 1'b1; rsp_entry = 2'd0;
      #1;
      chk_eq("R8 accepted as primary", miss_accept, 1);
      @(negedge clk);
      miss_valid = 1'b0; rsp_valid = 1'b0;
      chk_eq("R8 new request raised", req_valid, 1);
      chk_eq("R8 new entry index", req_entry, 1);
      chk_eq("R8 new request block", req_block, 27'h380);
      chk_done("R8 old target only", 6'd20, 1'b0, 3'd0);
      @(negedge clk);
      chk_eq("R8 no merged target replayed", done_valid, 0);
      do_rsp(2'd1);
      chk_done("R8 new entry replay", 6'd21, 1'b1, 3'd1);
      @(negedge clk);
      chk_eq("R8 new entry done", done_valid, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 20000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_primary();
      t_merge_and_refuse();
      t_fill();
      t_exhaust();
      t_same_cycle();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule